// File: doc/BRIEF.md
# Intra 4x4 Block Fetcher with Neighbour Reuse

This block sits in front of an intra 4x4 luma predictor. It takes raster pixels from a frame store, one horizontal strip of four picture lines at a time, into a local strip buffer. Once a whole strip is held it hands out the strip's 4x4 blocks from left to right. Each block comes with the thirteen reconstructed neighbour pixels that intra prediction needs and a four-bit availability mask.

Neighbours are never fetched from the frame store again. After the downstream pipeline has reconstructed a block, it writes that block back. The fetcher keeps the block's bottom row in a one-strip-wide line store. It keeps the block's right column and one saved corner pixel in registers. The next block is only offered after that write-back has been taken, so its left neighbours are always up to date. After the last strip of a picture the next strip is treated as the top of a new picture.

Top module: `intra4_fetch`

## Requirements
- R1: While reset is active and right after it, pix_ready is 1 and blk_valid and wb_ready are 0.
- R2: A strip is 4*IMG_W pixels in raster order (line 0 first, left to right). pix_ready is 1 until the last of them is accepted, then stays 0 until the write-back of the strip's last block is taken.
- R3: Blocks of a strip are issued left to right. Byte r*4+c of blk_pix (bits (r*4+c)*8 upward) is the strip pixel at line r, column 4*block+c.
- R4: blk_nbr bytes: byte 0 is the top-left corner, bytes 1..4 the row above left to right, bytes 5..8 the above-right row left to right, bytes 9..12 the left column top to bottom.
- R5: Neighbour values come from written-back pixels only. The left column is the right column of the previous written-back block. The above and above-right rows are the bottom rows written back for the strip above. The corner is the bottom-right pixel written back for the block above-left.
- R6: blk_avail bit 0 = left (block index > 0), bit 1 = top (strip index > 0), bit 2 = above-right (top and not the last block of the strip), bit 3 = corner (top and left). Every neighbour byte of a group that is not available is 0.
- R7: While blk_valid is 1 and blk_ready is 0, blk_valid stays 1 and blk_pix, blk_nbr and blk_avail stay unchanged.
- R8: After a block is accepted, blk_valid is 0 and wb_ready is 1 until a write-back is taken. No further block is shown before that.
- R9: wb_valid while wb_ready is 0 is ignored and changes no neighbour value.
- R10: The strip after the last strip of a picture (IMG_H/4 strips) has strip index 0, so its top, above-right and corner groups are unavailable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Raster pixel present |
| pix_ready | output | 1 | Strip buffer accepts pixels |
| pix_data | input | PIX_W | Raster pixel value |
| blk_valid | output | 1 | Block and neighbours present |
| blk_ready | input | 1 | Predictor takes the block |
| blk_pix | output | 16*PIX_W | 4x4 source block, raster packed |
| blk_nbr | output | 13*PIX_W | Thirteen neighbour pixels |
| blk_avail | output | 4 | Neighbour group availability |
| wb_valid | input | 1 | Reconstructed block present |
| wb_ready | output | 1 | Write-back is awaited |
| wb_pix | input | 16*PIX_W | Reconstructed 4x4 block, raster packed |

## Verification
Two small pictures are streamed with a position-dependent pixel pattern. The written-back blocks differ from the source by a fixed XOR, so neighbours taken from the source instead of the reconstruction are detected. Each block position is tried: first and last column, first strip, inner strips and the first strip of the second picture. Together these separate each availability case and the corner-save timing. Stalls of zero to two cycles on blk_ready test that the output holds. Garbage write-back pulses sent while the fetcher loads a strip must leave the next strip's neighbours unchanged.

// File: rtl/intra4_fetch_pkg.sv
package intra4_fetch_pkg;
  localparam int BLK_N  = 16;
  localparam int NBR_N  = 13;
  localparam int AV_LEFT = 0;
  localparam int AV_TOP  = 1;
  localparam int AV_TR   = 2;
  localparam int AV_TL   = 3;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_SHOW = 2'd1,
    ST_WAIT = 2'd2
  } fetch_st_t;
endpackage

// File: rtl/intra4_ctrl.sv
module intra4_ctrl
  import intra4_fetch_pkg::*;
#(
  parameter int IMG_W = 352,
  parameter int IMG_H = 288,
  localparam int NB = IMG_W / 4,
  localparam int NS = IMG_H / 4,
  localparam int CW = $clog2(IMG_W),
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  output logic          pix_ready,
  output logic          blk_valid,
  input  logic          blk_ready,
  input  logic          wb_valid,
  output logic          wb_ready,
  output logic          wr_en,
  output logic [1:0]    wr_row,
  output logic [CW-1:0] wr_col,
  output logic [BW-1:0] blk_idx,
  output logic          strip_first,
  output logic          blk_last,
  output logic          wb_take
);
  fetch_st_t     st_q, st_d;
  logic [CW-1:0] col_q, col_d;
  logic [1:0]    row_q, row_d;
  logic [BW-1:0] bx_q, bx_d;
  logic [SW-1:0] sy_q, sy_d;

  always_comb begin
    st_d  = st_q;
    col_d = col_q;
    row_d = row_q;
    bx_d  = bx_q;
    sy_d  = sy_q;
    unique case (st_q)
      ST_LOAD: begin
        if (pix_valid) begin
          if (col_q == CW'(IMG_W - 1)) begin
            col_d = '0;
            row_d = row_q + 2'd1;
            if (row_q == 2'd3) begin
              st_d = ST_SHOW;
              bx_d = '0;
            end
          end else begin
            col_d = col_q + CW'(1);
          end
        end
      end
      ST_SHOW: begin
        if (blk_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (wb_valid) begin
          if (bx_q == BW'(NB - 1)) begin
            st_d = ST_LOAD;
            sy_d = (sy_q == SW'(NS - 1)) ? '0 : sy_q + SW'(1);
          end else begin
            st_d = ST_SHOW;
            bx_d = bx_q + BW'(1);
          end
        end
      end
      default: st_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_LOAD;
      col_q <= '0;
      row_q <= '0;
      bx_q  <= '0;
      sy_q  <= '0;
    end else begin
      st_q  <= st_d;
      col_q <= col_d;
      row_q <= row_d;
      bx_q  <= bx_d;
      sy_q  <= sy_d;
    end
  end

  assign pix_ready   = (st_q == ST_LOAD);
  assign blk_valid   = (st_q == ST_SHOW);
  assign wb_ready    = (st_q == ST_WAIT);
  assign wr_en       = pix_ready && pix_valid;
  assign wr_row      = row_q;
  assign wr_col      = col_q;
  assign blk_idx     = bx_q;
  assign strip_first = (sy_q == '0);
  assign blk_last    = (bx_q == BW'(NB - 1));
  assign wb_take     = wb_ready && wb_valid;

  // R2: the strip completes only on the last pixel of line 3
  p_strip_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD) && (st_d == ST_SHOW) |-> (row_q == 2'd3) && wr_en);

  // R10: leaving the final strip returns to the picture top
  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_take && blk_last && (sy_q == SW'(NS - 1)) |=> strip_first);
endmodule

// File: rtl/intra4_strip_buf.sv
module intra4_strip_buf #(
  parameter int IMG_W = 352,
  parameter int PIX_W = 8,
  localparam int NB = IMG_W / 4,
  localparam int CW = $clog2(IMG_W),
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int BLK_BITS = 16 * PIX_W
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [1:0]          wr_row,
  input  logic [CW-1:0]       wr_col,
  input  logic [PIX_W-1:0]    wr_data,
  input  logic [BW-1:0]       rd_idx,
  output logic [BLK_BITS-1:0] rd_blk
);
  logic [BLK_BITS-1:0] mem [NB];
  logic [BW-1:0]       wr_blk;
  logic [3:0]          wr_pos;

  assign wr_blk = wr_col[CW-1:2];
  assign wr_pos = {wr_row, wr_col[1:0]};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_blk][wr_pos*PIX_W +: PIX_W] <= wr_data;
  end

  assign rd_blk = mem[rd_idx];
endmodule

// File: rtl/intra4_nbr_cache.sv
module intra4_nbr_cache
  import intra4_fetch_pkg::*;
#(
  parameter int IMG_W = 352,
  parameter int PIX_W = 8,
  localparam int NB = IMG_W / 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int ROW_BITS = 4 * PIX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BW-1:0]          blk_idx,
  input  logic                   strip_first,
  input  logic                   blk_last,
  input  logic                   wb_take,
  input  logic [16*PIX_W-1:0]    wb_pix,
  output logic [NBR_N*PIX_W-1:0] nbr,
  output logic [3:0]             avail
);
  logic [ROW_BITS-1:0] line_q [NB];
  logic [ROW_BITS-1:0] left_q, left_d;
  logic [PIX_W-1:0]    corner_q, corner_d;
  logic [ROW_BITS-1:0] top_row, tr_row;
  logic [BW-1:0]       tr_idx;

  assign tr_idx  = blk_last ? blk_idx : blk_idx + BW'(1);
  assign top_row = line_q[blk_idx];
  assign tr_row  = line_q[tr_idx];

  always_comb begin
    left_d   = left_q;
    corner_d = corner_q;
    if (wb_take) begin
      for (int r = 0; r < 4; r++) left_d[r*PIX_W +: PIX_W] = wb_pix[(r*4+3)*PIX_W +: PIX_W];
      corner_d = top_row[ROW_BITS-1 -: PIX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      corner_q <= '0;
    end else begin
      left_q   <= left_d;
      corner_q <= corner_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wb_take) line_q[blk_idx] <= wb_pix[16*PIX_W-1 -: ROW_BITS];
  end

  always_comb begin
    avail[AV_LEFT] = (blk_idx != '0);
    avail[AV_TOP]  = !strip_first;
    avail[AV_TR]   = !strip_first && !blk_last;
    avail[AV_TL]   = !strip_first && (blk_idx != '0);
  end

  assign nbr = { avail[AV_LEFT] ? left_q   : {ROW_BITS{1'b0}},
                 avail[AV_TR]   ? tr_row   : {ROW_BITS{1'b0}},
                 avail[AV_TOP]  ? top_row  : {ROW_BITS{1'b0}},
                 avail[AV_TL]   ? corner_q : {PIX_W{1'b0}} };

  // R5: a taken write-back of a non-final block becomes the next left column
  p_left_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_take && !blk_last |=> nbr[9*PIX_W +: ROW_BITS] ==
      {$past(wb_pix[15*PIX_W +: PIX_W]), $past(wb_pix[11*PIX_W +: PIX_W]),
       $past(wb_pix[7*PIX_W +: PIX_W]),  $past(wb_pix[3*PIX_W +: PIX_W])});
endmodule

// File: rtl/intra4_fetch.sv
module intra4_fetch
  import intra4_fetch_pkg::*;
#(
  parameter int IMG_W = 352,
  parameter int IMG_H = 288,
  parameter int PIX_W = 8,
  localparam int NB = IMG_W / 4,
  localparam int CW = $clog2(IMG_W),
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pix_valid,
  output logic                   pix_ready,
  input  logic [PIX_W-1:0]       pix_data,
  output logic                   blk_valid,
  input  logic                   blk_ready,
  output logic [16*PIX_W-1:0]    blk_pix,
  output logic [NBR_N*PIX_W-1:0] blk_nbr,
  output logic [3:0]             blk_avail,
  input  logic                   wb_valid,
  output logic                   wb_ready,
  input  logic [16*PIX_W-1:0]    wb_pix
);
  logic [1:0]    rs_q;
  logic          rst_sn;
  logic          wr_en;
  logic [1:0]    wr_row;
  logic [CW-1:0] wr_col;
  logic [BW-1:0] blk_idx;
  logic          strip_first, blk_last, wb_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  intra4_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
    .clk(clk), .rst_n(rst_sn),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .blk_valid(blk_valid), .blk_ready(blk_ready),
    .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .blk_idx(blk_idx), .strip_first(strip_first),
    .blk_last(blk_last), .wb_take(wb_take)
  );

  intra4_strip_buf #(.IMG_W(IMG_W), .PIX_W(PIX_W)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(pix_data), .rd_idx(blk_idx), .rd_blk(blk_pix)
  );

  intra4_nbr_cache #(.IMG_W(IMG_W), .PIX_W(PIX_W)) u_nbr (
    .clk(clk), .rst_n(rst_sn), .blk_idx(blk_idx),
    .strip_first(strip_first), .blk_last(blk_last),
    .wb_take(wb_take), .wb_pix(wb_pix),
    .nbr(blk_nbr), .avail(blk_avail)
  );

  // R7: an offered block holds until taken
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_pix)
                                && $stable(blk_nbr) && $stable(blk_avail));

  // R8: acceptance leads to waiting for write-back
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    blk_valid && blk_ready |=> !blk_valid && wb_ready);

  // R2: pixel intake never overlaps block issue
  p_load_excl_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    pix_ready |-> !blk_valid && !wb_ready);

  // R6: a missing left group reads as zero
  p_left_zero_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    blk_valid && !blk_avail[AV_LEFT] |-> blk_nbr[9*PIX_W +: 4*PIX_W] == '0);
endmodule

// File: tb/sim_intra4_fetch.sv
`timescale 1ns/1ps
module sim_intra4_fetch;
  localparam int W = 16;
  localparam int H = 12;
  localparam int NB = W / 4;
  localparam int NS = H / 4;
  localparam int FRAMES = 2;
  localparam int TOTAL = FRAMES * NS * NB;

  typedef struct {
    logic [127:0] pix;
    logic [103:0] nbr;
    logic [3:0]   av;
    logic [127:0] wb;
    logic         last;
    string        avtag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic pix_valid, pix_ready, blk_valid, blk_ready, wb_valid, wb_ready;
  logic [7:0]   pix_data;
  logic [127:0] blk_pix, wb_pix;
  logic [103:0] blk_nbr;
  logic [3:0]   blk_avail;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intra4_fetch #(.IMG_W(W), .IMG_H(H), .PIX_W(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_pix(blk_pix), .blk_nbr(blk_nbr), .blk_avail(blk_avail),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_pix(wb_pix)
  );

  function automatic logic [7:0] img(int f, int y, int x);
    return 8'((y * 7 + x * 13 + f * 29 + 1) & 255);
  endfunction

  function automatic logic [7:0] rec(int f, int y, int x);
    return img(f, y, x) ^ 8'h5A;
  endfunction

  task automatic chk(string rq, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  function automatic item_t make_item(int f, int s, int bx);
    item_t it;
    int y0 = 4 * s;
    int x0 = 4 * bx;
    it.pix = '0; it.nbr = '0; it.wb = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        it.pix[(r*4+c)*8 +: 8] = img(f, y0 + r, x0 + c);
        it.wb[(r*4+c)*8 +: 8]  = rec(f, y0 + r, x0 + c);
      end
    it.av = {(s > 0 && bx > 0), (s > 0 && bx < NB - 1), (s > 0), (bx > 0)};
    if (it.av[3]) it.nbr[7:0] = rec(f, y0 - 1, x0 - 1);
    for (int k = 0; k < 4; k++) begin
      if (it.av[1]) it.nbr[(1+k)*8 +: 8] = rec(f, y0 - 1, x0 + k);
      if (it.av[2]) it.nbr[(5+k)*8 +: 8] = rec(f, y0 - 1, x0 + 4 + k);
      if (it.av[0]) it.nbr[(9+k)*8 +: 8] = rec(f, y0 + k, x0 - 1);
    end
    it.last = (bx == NB - 1);
    it.avtag = (f > 0 && s == 0) ? "R10 avail after picture wrap" : "R6 avail";
    return it;
  endfunction

  task automatic send_pix(logic [7:0] d);
    @(negedge clk);
    pix_valid = 1'b1;
    pix_data  = d;
    while (!pix_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // reset and driver
  initial begin
    rst_n = 1'b0; pix_valid = 1'b0; pix_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 pix_ready in reset", 128'(pix_ready), 128'(1));
    chk("R1 blk_valid in reset", 128'(blk_valid), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pix_ready after reset", 128'(pix_ready), 128'(1));
    chk("R1 blk_valid after reset", 128'(blk_valid), 128'(0));
    chk("R1 wb_ready after reset", 128'(wb_ready), 128'(0));
    started = 1;
    for (int f = 0; f < FRAMES; f++)
      for (int s = 0; s < NS; s++) begin
        for (int bx = 0; bx < NB; bx++) q.push_back(make_item(f, s, bx));
        for (int y = 0; y < 4; y++)
          for (int x = 0; x < W; x++) send_pix(img(f, 4 * s + y, x));
        @(negedge clk);
        pix_valid = 1'b0;
        chk("R2 pix_ready low after strip", 128'(pix_ready), 128'(0));
      end
  end

  // monitor
  initial begin
    item_t it;
    blk_ready = 1'b0; wb_valid = 1'b0; wb_pix = '0;
    wait (started);
    for (int i = 0; i < TOTAL; i++) begin
      @(negedge clk);
      while (!blk_valid) @(negedge clk);
      it = q.pop_front();
      chk("R3 block pixels", blk_pix, it.pix);
      chk("R5 neighbours (R4 order)", 128'(blk_nbr), 128'(it.nbr));
      chk(it.avtag, 128'(blk_avail), 128'(it.av));
      for (int k = 0; k < i % 3; k++) begin
        @(negedge clk);
        chk("R7 held under stall", {blk_valid, blk_nbr[22:0], blk_pix[103:0]},
            {1'b1, it.nbr[22:0], it.pix[103:0]});
      end
      blk_ready = 1'b1;
      @(negedge clk);
      blk_ready = 1'b0;
      chk("R8 no block before write-back", 128'(blk_valid), 128'(0));
      chk("R8 wb_ready after accept", 128'(wb_ready), 128'(1));
      @(negedge clk);
      chk("R8 still waiting", 128'({blk_valid, wb_ready}), 128'(2'b01));
      wb_valid = 1'b1;
      wb_pix   = it.wb;
      @(negedge clk);
      wb_valid = 1'b0;
      if (it.last) begin
        chk("R2 pix_ready after last write-back", 128'(pix_ready), 128'(1));
        chk("R9 wb_ready low while loading", 128'(wb_ready), 128'(0));
        wb_valid = 1'b1;
        wb_pix   = ~it.wb;
        repeat (3) @(negedge clk);
        wb_valid = 1'b0;
      end
    end
    done = 1;
    report();
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=%0d blocks", TOTAL);
      report();
    end
  end
endmodule